// File: doc/BRIEF.md
# Dual-Channel Gate Scan Clock Controller

This block decides, once per system clock, how the high-voltage stage of a display row driver should drive a two-channel gate scan clock pair and the start pulse. It samples a frame sync, one vertical clock pulse per channel and an enable. It returns a 2-bit drive code for each channel's clock output and for that output's complement. It also returns a switch enable that ties the two outputs together for charge sharing, a drive code for the start pulse, and a one-cycle marker for each new frame. The level shifters downstream turn each code into a connection to the gate-on rail, a connection to the gate-off rail, or an open output.

Each channel holds a toggle bit. The toggle flips on every falling edge of that channel's clock pulse while the block is enabled. When the channel's clock pulse and the frame sync are both low, both outputs float and the share switch closes, so a change of level always passes through a charge-sharing interval first. All inputs are asynchronous to the system clock and pass through a two-flop synchronizer. Every output is registered, so an input change shows on the outputs on the third rising clock edge after it is applied.

Top module: `gate_scan_ctrl`

## Requirements
- R1: While the synchronous active-high reset is held, and on the first cycle after it, every drive code is the low code, every share switch is open and the frame marker is 0 (with all inputs low).
- R2: Drive codes are 2'b00 = low, 2'b01 = high and 2'b10 = high impedance. Code 2'b11 never appears on any drive output.
- R3: While enabled, a channel's toggle bit inverts on each falling edge of that channel's clock pulse input. A non-floating clock output shows the high code when the toggle is 1 and the low code when it is 0. An input change reaches the outputs on the third rising clock edge after it is applied.
- R4: While enabled, a channel's clock and complement outputs both carry the high-impedance code exactly when that channel's clock pulse input and the frame sync are both low.
- R5: A channel's share enable is 1 exactly when that channel's clock output carries the high-impedance code, and 0 otherwise.
- R6: While enabled and not floating, the complement output carries the opposite level code to the clock output.
- R7: The start drive code is low when the frame sync is low, high when the frame sync is high and channel 0's clock pulse is low, and high impedance when both are high. While disabled it is low.
- R8: While the enable is low, all clock, complement and start codes are low, the share switches are open, and every toggle bit returns to 0.
- R9: A rising edge of the synchronized frame sync while enabled produces a frame marker pulse exactly one cycle wide. There is one pulse per edge.
- R10: A falling edge on one channel's clock pulse leaves the other channel's toggle bit unchanged.
- R11: A falling clock pulse edge while the frame sync is low first gives high impedance with the switch closed. When the clock pulse rises again, the output shows the newly toggled level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable_in | input | 1 | Block enable, asynchronous |
| frame_sync_in | input | 1 | Frame sync, asynchronous |
| vclk_in | input | NCH | Per-channel vertical clock pulse, asynchronous |
| ckp_drv | output | 2*NCH | Clock output drive code, channel i in bits [2i+1:2i] |
| ckn_drv | output | 2*NCH | Complement output drive code, same packing |
| share_en | output | NCH | Charge-share switch enable per channel |
| start_drv | output | 2 | Start pulse drive code |
| frame_start | output | 1 | One-cycle marker for a new frame |

## Verification
The hardest case to reach is a toggle that enters through the charge-sharing interval. The frame sync has to be low while the channel's clock pulse falls, and the clock pulse must later rise while the frame sync stays low, so that the new level appears. Random enables in between keep clearing the toggle bits. The stimulus sets up this sequence directly, first on one channel and then on the other, and checks the code on the exact cycle where the synchronizer and output register latency places it. Long random runs, weighted toward an enabled block, then mix in enable drops that arrive on the same step as clock falls.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  typedef enum logic [1:0] {
    DRV_LO = 2'b00,
    DRV_HI = 2'b01,
    DRV_Z  = 2'b10
  } drv_t;
endpackage

// File: rtl/gsc_sync.sv
module gsc_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_async;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/gsc_channel.sv
module gsc_channel
  import gsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       fsync,
  input  logic       vclk,
  output logic [1:0] ckp_code,
  output logic [1:0] ckn_code,
  output logic       share
);
  logic vclk_q;
  logic tog_q;
  logic fall;
  logic tog_nxt;
  logic idle;
  drv_t ckp_q, ckn_q;

  always_comb begin
    fall    = vclk_q & ~vclk;
    tog_nxt = en ? (tog_q ^ fall) : 1'b0;
    idle    = ~vclk & ~fsync;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vclk_q <= 1'b0;
      tog_q  <= 1'b0;
      ckp_q  <= DRV_LO;
      ckn_q  <= DRV_LO;
      share  <= 1'b0;
    end else begin
      vclk_q <= vclk;
      tog_q  <= tog_nxt;
      if (!en) begin
        ckp_q <= DRV_LO;
        ckn_q <= DRV_LO;
        share <= 1'b0;
      end else if (idle) begin
        ckp_q <= DRV_Z;
        ckn_q <= DRV_Z;
        share <= 1'b1;
      end else begin
        ckp_q <= tog_nxt ? DRV_HI : DRV_LO;
        ckn_q <= tog_nxt ? DRV_LO : DRV_HI;
        share <= 1'b0;
      end
    end
  end

  assign ckp_code = ckp_q;
  assign ckn_code = ckn_q;
endmodule

// File: rtl/gsc_start.sv
module gsc_start
  import gsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       fsync,
  input  logic       vclk0,
  output logic [1:0] start_code,
  output logic       frame_mark
);
  logic fsync_q;
  drv_t start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsync_q    <= 1'b0;
      start_q    <= DRV_LO;
      frame_mark <= 1'b0;
    end else begin
      fsync_q    <= fsync;
      frame_mark <= en & fsync & ~fsync_q;
      if (!en || !fsync) start_q <= DRV_LO;
      else if (!vclk0)   start_q <= DRV_HI;
      else               start_q <= DRV_Z;
    end
  end

  assign start_code = start_q;
endmodule

// File: rtl/gate_scan_ctrl.sv
module gate_scan_ctrl #(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_in,
  input  logic             frame_sync_in,
  input  logic [NCH-1:0]   vclk_in,
  output logic [2*NCH-1:0] ckp_drv,
  output logic [2*NCH-1:0] ckn_drv,
  output logic [NCH-1:0]   share_en,
  output logic [1:0]       start_drv,
  output logic             frame_start
);
  localparam int SW = NCH + 2;

  logic [SW-1:0]  raw_bus;
  logic [SW-1:0]  syn_bus;
  logic           en_s;
  logic           fs_s;
  logic [NCH-1:0] vclk_s;

  assign raw_bus = {enable_in, frame_sync_in, vclk_in};

  gsc_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_bus),
    .q_sync  (syn_bus)
  );

  assign en_s   = syn_bus[SW-1];
  assign fs_s   = syn_bus[SW-2];
  assign vclk_s = syn_bus[NCH-1:0];

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      gsc_channel u_ch (
        .clk      (clk),
        .rst      (rst),
        .en       (en_s),
        .fsync    (fs_s),
        .vclk     (vclk_s[c]),
        .ckp_code (ckp_drv[2*c+1:2*c]),
        .ckn_code (ckn_drv[2*c+1:2*c]),
        .share    (share_en[c])
      );
    end
  endgenerate

  gsc_start u_start (
    .clk        (clk),
    .rst        (rst),
    .en         (en_s),
    .fsync      (fs_s),
    .vclk0      (vclk_s[0]),
    .start_code (start_drv),
    .frame_mark (frame_start)
  );
endmodule

// File: rtl/gsc_checker.sv
module gsc_checker #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             enable_in,
  input logic             frame_sync_in,
  input logic [NCH-1:0]   vclk_in,
  input logic [2*NCH-1:0] ckp_drv,
  input logic [2*NCH-1:0] ckn_drv,
  input logic [NCH-1:0]   share_en,
  input logic [1:0]       start_drv,
  input logic             frame_start
);
  logic [2:0] cyc;

  always_ff @(posedge clk) begin
    if (rst)           cyc <= '0;
    else if (cyc != 7) cyc <= cyc + 3'd1;
  end

  assert_start_code_R2: assert property (@(posedge clk) disable iff (rst)
    start_drv != 2'b11);

  assert_start_hi_R7: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 4 && $past(enable_in,3) && $past(frame_sync_in,3) && !$past(vclk_in[0],3))
    |-> start_drv == 2'b01);

  assert_pulse_width_R9: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chk
      assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
        ckp_drv[2*i+1:2*i] != 2'b11 && ckn_drv[2*i+1:2*i] != 2'b11);

      assert_share_float_R5: assert property (@(posedge clk) disable iff (rst)
        share_en[i] == (ckp_drv[2*i+1:2*i] == 2'b10));

      assert_pair_float_R6: assert property (@(posedge clk) disable iff (rst)
        (ckp_drv[2*i+1:2*i] == 2'b10) == (ckn_drv[2*i+1:2*i] == 2'b10));

      assert_cpl_hi_R6: assert property (@(posedge clk) disable iff (rst)
        (ckp_drv[2*i+1:2*i] == 2'b01) |-> (ckn_drv[2*i+1:2*i] == 2'b00));

      assert_cpl_lo_R6: assert property (@(posedge clk) disable iff (rst)
        (ckn_drv[2*i+1:2*i] == 2'b01) |-> (ckp_drv[2*i+1:2*i] == 2'b00));

      assert_float_R4: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 4 && $past(enable_in,3) && !$past(frame_sync_in,3) && !$past(vclk_in[i],3))
        |-> ckp_drv[2*i+1:2*i] == 2'b10);

      assert_disabled_low_R8: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 4 && !$past(enable_in,3))
        |-> (ckp_drv[2*i+1:2*i] == 2'b00 && ckn_drv[2*i+1:2*i] == 2'b00 && !share_en[i]));
    end
  endgenerate
endmodule

bind gate_scan_ctrl gsc_checker #(.NCH(NCH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .enable_in     (enable_in),
  .frame_sync_in (frame_sync_in),
  .vclk_in       (vclk_in),
  .ckp_drv       (ckp_drv),
  .ckn_drv       (ckn_drv),
  .share_en      (share_en),
  .start_drv     (start_drv),
  .frame_start   (frame_start)
);

// File: tb/gate_scan_ctrl_bench.sv
module gate_scan_ctrl_bench;
  localparam int NCH = 2;
  localparam logic [1:0] LO = 2'b00, HI = 2'b01, HZ = 2'b10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             enable_in = 1'b0;
  logic             frame_sync_in = 1'b0;
  logic [NCH-1:0]   vclk_in = '0;
  logic [2*NCH-1:0] ckp_drv, ckn_drv;
  logic [NCH-1:0]   share_en;
  logic [1:0]       start_drv;
  logic             frame_start;

  int n_cmp = 0;
  int n_bad = 0;
  int got_pulses = 0;
  int exp_pulses = 0;
  bit finished = 0;

  logic [NCH-1:0] m_tog = '0;
  logic [NCH-1:0] m_prev_v = '0;
  logic           m_prev_fs = 1'b0;
  logic           m_en = 1'b0;
  logic           m_fs = 1'b0;
  logic [NCH-1:0] m_v = '0;

  always #4 clk = ~clk;

  gate_scan_ctrl #(.NCH(NCH)) u_gate_scan_ctrl (
    .clk           (clk),
    .rst           (rst),
    .enable_in     (enable_in),
    .frame_sync_in (frame_sync_in),
    .vclk_in       (vclk_in),
    .ckp_drv       (ckp_drv),
    .ckn_drv       (ckn_drv),
    .share_en      (share_en),
    .start_drv     (start_drv),
    .frame_start   (frame_start)
  );

  always @(negedge clk) if (!rst && frame_start) got_pulses++;

  function automatic logic [1:0] exp_ckp(input logic en, fs, v, tog);
    if (!en) return LO;
    if (!v && !fs) return HZ;
    return tog ? HI : LO;
  endfunction

  function automatic logic [1:0] exp_ckn(input logic en, fs, v, tog);
    if (!en) return LO;
    if (!v && !fs) return HZ;
    return tog ? LO : HI;
  endfunction

  function automatic logic [1:0] exp_start(input logic en, fs, v0);
    if (!en || !fs) return LO;
    if (!v0) return HI;
    return HZ;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Model update for a new input vector, applied at the same instant as the drive
  task automatic model_apply(input logic en, fs, input logic [NCH-1:0] v);
    for (int c = 0; c < NCH; c++) begin
      if (!en) m_tog[c] = 1'b0;
      else if (m_prev_v[c] && !v[c]) m_tog[c] = ~m_tog[c];
    end
    if (en && fs && !m_prev_fs) exp_pulses++;
    m_prev_v  = v;
    m_prev_fs = fs;
    m_en = en; m_fs = fs; m_v = v;
  endtask

  task automatic check_all(input string ctx);
    for (int c = 0; c < NCH; c++) begin
      chk({ctx, " R3 ckp"}, ckp_drv[2*c+:2], exp_ckp(m_en, m_fs, m_v[c], m_tog[c]));
      chk({ctx, " R6 ckn"}, ckn_drv[2*c+:2], exp_ckn(m_en, m_fs, m_v[c], m_tog[c]));
      chk({ctx, " R5 share"}, share_en[c],
          (m_en && !m_v[c] && !m_fs) ? 1 : 0);
    end
    chk({ctx, " R7 start"}, start_drv, exp_start(m_en, m_fs, m_v[0]));
  endtask

  // Called at a negedge; holds the inputs for 4 rising edges, then checks
  task automatic step(input logic en, fs, input logic [NCH-1:0] v, input string ctx);
    enable_in = en; frame_sync_in = fs; vclk_in = v;
    model_apply(en, fs, v);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_all(ctx);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] prev_code;
    void'($urandom(32'd20141109));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 ckp", ckp_drv, 0);
    chk("R1 ckn", ckn_drv, 0);
    chk("R1 share", share_en, 0);
    chk("R1 start", start_drv, 0);
    chk("R1 frame", frame_start, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 first cycle ckp", ckp_drv, 0);

    // R4/R5: enabled with everything low -> both channels float, switches closed
    step(1'b1, 1'b0, 2'b00, "R4 idle float");
    // R3: rising clocks, no toggle yet -> low level
    step(1'b1, 1'b0, 2'b11, "R3 pre-toggle");
    // R3 latency: fall on channel 0 with sync low appears on the third edge
    prev_code = ckp_drv[1:0];
    enable_in = 1'b1; frame_sync_in = 1'b0; vclk_in = 2'b10;
    model_apply(1'b1, 1'b0, 2'b10);
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R3 latency two edges", ckp_drv[1:0], prev_code);
    @(posedge clk); @(negedge clk);
    chk("R3 latency third edge", ckp_drv[1:0], HZ);
    chk("R11 share during transition", share_en[0], 1);
    // R10: channel 1 untouched by channel 0 fall
    chk("R10 other channel", ckp_drv[3:2], HI & 2'b00);
    // R11: rise again -> new toggled level (high)
    step(1'b1, 1'b0, 2'b11, "R11 settle");
    chk("R11 new level", ckp_drv[1:0], HI);
    // R10: channel 1 falls and rises while channel 0 holds
    step(1'b1, 1'b0, 2'b01, "R10 ch1 fall");
    step(1'b1, 1'b0, 2'b11, "R10 ch1 rise");
    chk("R10 ch0 kept", ckp_drv[1:0], HI);
    chk("R10 ch1 toggled", ckp_drv[3:2], HI);
    // R7: start pulse decode, with frame marker R9
    step(1'b1, 1'b1, 2'b10, "R7 start high");
    step(1'b1, 1'b1, 2'b11, "R7 start float");
    step(1'b1, 1'b0, 2'b11, "R7 start low");
    chk("R9 pulse count", got_pulses, exp_pulses);
    // Toggle with sync high: direct level change, no float
    step(1'b1, 1'b1, 2'b10, "R3 fall sync high");
    // R8: disable clears everything and the toggle bits
    step(1'b0, 1'b1, 2'b11, "R8 disabled");
    chk("R8 start low", start_drv, LO);
    step(1'b1, 1'b1, 2'b11, "R8 toggles cleared");
    chk("R8 ch0 after enable", ckp_drv[1:0], LO);
    chk("R8 ch1 after enable", ckp_drv[3:2], LO);
    // R9: sync rise while disabled gives no marker
    step(1'b0, 1'b0, 2'b11, "R9 prep");
    step(1'b0, 1'b1, 2'b11, "R9 disabled edge");
    chk("R9 no pulse disabled", got_pulses, exp_pulses);

    // Random mix, weighted toward enabled
    for (int k = 0; k < 400; k++) begin
      logic en_r, fs_r;
      logic [NCH-1:0] v_r;
      en_r = ($urandom % 8) != 0;
      fs_r = ($urandom % 3) == 0;
      v_r  = NCH'($urandom);
      step(en_r, fs_r, v_r, "random");
    end
    step(1'b1, 1'b0, 2'b00, "R2 end");
    chk("R2 legal ckp", (ckp_drv[1:0] != 2'b11 && ckp_drv[3:2] != 2'b11) ? 1 : 0, 1);
    chk("R9 total pulses", got_pulses, exp_pulses);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule